// File: doc/BRIEF.md
# Idle-Locked Stream Descrambler

This block recovers plaintext from a bit-serial scrambled line stream, one bit per receive clock. The transmitter adds a free-running key stream to every bit, and that key stream never restarts between frames. The receiver cannot simply restart its own key generator at frame boundaries, so it has to learn the key from the line.

It does this by assuming the link is idle. Between frames the plaintext is a steady run of ones, so the inverse of each received bit is a guess at the key bit. The block shifts these guesses into an 11-bit key register. It then predicts each next key bit with the generator polynomial x^11 + x^9 + 1 and compares the prediction with the next guess. After enough consecutive agreements it declares lock.

Once locked, the key register steps freely, and each output bit is the received bit XORed with the predicted key bit. An idle watchdog drops lock if no idle stretch is seen within a timeout. The block then returns to acquisition.

Top module: `idle_lock_descrambler`

## Requirements
- R1: While the synchronous reset is high, and on the clock after it, `locked_o` reads 0 and `plain_o` reads 1.
- R2: `plain_o` reads 1 on every clock that follows a clock on which `locked_o` was 0.
- R3: After reset, with idle plaintext (all ones) on the line, `locked_o` is still 0 after the 42nd received bit and rises on the clock edge that samples the 43rd bit. This count is 11 fill bits followed by 32 matching predictions.
- R4: While locked, `plain_o` one clock after a bit is sampled equals that bit XOR the key bit of the generator x^11 + x^9 + 1. The newest key bit is the XOR of the key bits 11 and 9 positions back. The generator keeps stepping across frame boundaries, so random frame data is returned exactly.
- R5: During acquisition, one wrong prediction reloads the key register from the latest 11 guesses and restarts the match count. With a single corrupted idle bit at position 21, lock is not declared by bit 43, but it is still reached later on idle.
- R6: Outside the fill phase, a key register that reads all zeros is forced to 11'h001 on the next clock. Because of this, a line of constant ones (a guessed key of all zeros) never produces lock.
- R7: While locked, any run of 10 or more descrambled ones restarts a 2^16-clock idle timer. If the timer expires, lock is dropped on the 65536th clock after the last such run.
- R8: After lock is dropped, idle plaintext brings lock back after exactly 43 more bits, and plaintext is then correct again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cipher_in | input | 1 | Scrambled line bit |
| plain_o | output | 1 | Registered descrambled bit; reads 1 while unlocked |
| locked_o | output | 1 | Registered lock flag |

## Verification
Some properties are checked on every cycle. The output is held at one while unlocked. Lock is only entered from a full match count. The key register escapes the all-zero state at once and never reads zero while locked. Lock only falls when the idle timer has reached its last value.

Other behaviour only the bench scenarios can show. These are that the learned key matches the transmitter's free-running generator across frames, the exact lock latency of 43 bits, the delay caused by a corrupted guess, and re-acquisition after a timeout.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   // acquisition and lock phases of the descrambler
   typedef enum logic [1:0] {
      DSC_FILL  = 2'd0,
      DSC_CHECK = 2'd1,
      DSC_LOCK  = 2'd2
   } dsc_state_e;
endpackage

// File: rtl/dsc_key_lfsr.sv
// Key register: loaded from guessed key bits or stepped by its own feedback.
module dsc_key_lfsr #(
   parameter int KEY_W = 11,
   parameter int TAP_B = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             guard_en,
   input  logic             shift_hyp,
   input  logic             shift_pred,
   input  logic             hyp_bit,
   output logic [KEY_W-1:0] key_q,
   output logic             pred_bit,
   output logic             key_zero
);
   localparam logic [KEY_W-1:0] KEY_ESCAPE = KEY_W'(1);

   if (KEY_W < 3) begin : g_bad_width
      $error("dsc_key_lfsr: KEY_W must be at least 3");
   end
   if (TAP_B < 1 || TAP_B >= KEY_W) begin : g_bad_tap
      $error("dsc_key_lfsr: TAP_B must lie in 1..KEY_W-1");
   end

   // newest key bit from the bits KEY_W and TAP_B positions back
   assign pred_bit = key_q[KEY_W-1] ^ key_q[TAP_B-1];
   assign key_zero = (key_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         key_q <= '0;
      end else if (guard_en && key_zero) begin
         key_q <= KEY_ESCAPE;
      end else if (shift_hyp) begin
         key_q <= {key_q[KEY_W-2:0], hyp_bit};
      end else if (shift_pred) begin
         key_q <= {key_q[KEY_W-2:0], pred_bit};
      end
   end
endmodule

// File: rtl/dsc_lock_fsm.sv
// Fill / check / lock sequencing with fill and match counters.
module dsc_lock_fsm import dsc_pkg::*; #(
   parameter int KEY_W   = 11,
   parameter int MATCH_N = 32
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       hyp_bit,
   input  logic                       pred_bit,
   input  logic                       key_zero,
   input  logic                       timeout,
   output dsc_state_e                 state_q,
   output logic [$clog2(MATCH_N)-1:0] match_q,
   output logic                       shift_hyp,
   output logic                       shift_pred,
   output logic                       guard_en
);
   localparam int FCW = $clog2(KEY_W);
   localparam int MCW = $clog2(MATCH_N);
   localparam logic [FCW-1:0] FILL_LAST  = FCW'(KEY_W - 1);
   localparam logic [MCW-1:0] MATCH_LAST = MCW'(MATCH_N - 1);

   if (MATCH_N < 2) begin : g_bad_match
      $error("dsc_lock_fsm: MATCH_N must be at least 2");
   end

   logic [FCW-1:0] fill_q;

   always_comb begin
      shift_hyp  = (state_q != DSC_LOCK);
      shift_pred = (state_q == DSC_LOCK);
      guard_en   = (state_q != DSC_FILL);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= DSC_FILL;
         fill_q  <= '0;
         match_q <= '0;
      end else begin
         case (state_q)
            DSC_FILL: begin
               if (fill_q == FILL_LAST) begin
                  state_q <= DSC_CHECK;
                  fill_q  <= '0;
                  match_q <= '0;
               end else begin
                  fill_q <= fill_q + 1'b1;
               end
            end
            DSC_CHECK: begin
               if (key_zero) begin
                  match_q <= '0;
               end else if (pred_bit == hyp_bit) begin
                  if (match_q == MATCH_LAST) begin
                     state_q <= DSC_LOCK;
                     match_q <= '0;
                  end else begin
                     match_q <= match_q + 1'b1;
                  end
               end else begin
                  match_q <= '0;
               end
            end
            DSC_LOCK: begin
               if (timeout) begin
                  state_q <= DSC_FILL;
                  fill_q  <= '0;
               end
            end
            default: state_q <= DSC_FILL;
         endcase
      end
   end
endmodule

// File: rtl/dsc_idle_monitor.sv
// Watches descrambled ones runs while locked and times out without idle.
module dsc_idle_monitor #(
   parameter int IDLE_RUN  = 10,
   parameter int TIMEOUT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 active,
   input  logic                 plain_bit,
   output logic                 timeout,
   output logic [TIMEOUT_W-1:0] timer_q
);
   localparam int RCW = $clog2(IDLE_RUN);
   localparam logic [RCW-1:0] RUN_LAST = RCW'(IDLE_RUN - 1);

   if (IDLE_RUN < 2) begin : g_bad_run
      $error("dsc_idle_monitor: IDLE_RUN must be at least 2");
   end
   if (TIMEOUT_W < 2) begin : g_bad_timer
      $error("dsc_idle_monitor: TIMEOUT_W must be at least 2");
   end

   logic [RCW-1:0] run_q;
   logic           kick;

   assign kick    = active && plain_bit && (run_q == RUN_LAST);
   assign timeout = active && !kick && (timer_q == '1);

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         run_q <= '0;
      end else if (plain_bit) begin
         if (run_q != RUN_LAST) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !active || kick) begin
         timer_q <= '0;
      end else begin
         timer_q <= timer_q + 1'b1;
      end
   end
endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler import dsc_pkg::*; #(
   parameter int KEY_W     = 11,
   parameter int TAP_B     = 9,
   parameter int MATCH_N   = 32,
   parameter int IDLE_RUN  = 10,
   parameter int TIMEOUT_W = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic cipher_in,
   output logic plain_o,
   output logic locked_o
);
   localparam int MCW = $clog2(MATCH_N);

   dsc_state_e           state_q;
   logic [KEY_W-1:0]     key_q;
   logic [MCW-1:0]       match_q;
   logic [TIMEOUT_W-1:0] timer_q;
   logic hyp_bit, pred_bit, key_zero, timeout;
   logic shift_hyp, shift_pred, guard_en;
   logic plain_bit, filling;

   // idle plaintext is all ones, so the inverted line bit guesses the key
   assign hyp_bit   = ~cipher_in;
   assign plain_bit = cipher_in ^ pred_bit;
   assign locked_o  = (state_q == DSC_LOCK);
   assign filling   = (state_q == DSC_FILL);

   dsc_key_lfsr #(.KEY_W(KEY_W), .TAP_B(TAP_B)) i_key (
      .clk(clk), .rst(rst), .guard_en(guard_en), .shift_hyp(shift_hyp),
      .shift_pred(shift_pred), .hyp_bit(hyp_bit), .key_q(key_q),
      .pred_bit(pred_bit), .key_zero(key_zero)
   );

   dsc_lock_fsm #(.KEY_W(KEY_W), .MATCH_N(MATCH_N)) i_fsm (
      .clk(clk), .rst(rst), .hyp_bit(hyp_bit), .pred_bit(pred_bit),
      .key_zero(key_zero), .timeout(timeout), .state_q(state_q),
      .match_q(match_q), .shift_hyp(shift_hyp), .shift_pred(shift_pred),
      .guard_en(guard_en)
   );

   dsc_idle_monitor #(.IDLE_RUN(IDLE_RUN), .TIMEOUT_W(TIMEOUT_W)) i_idle (
      .clk(clk), .rst(rst), .active(locked_o), .plain_bit(plain_bit),
      .timeout(timeout), .timer_q(timer_q)
   );

   always_ff @(posedge clk) begin
      if (rst) plain_o <= 1'b1;
      else     plain_o <= locked_o ? plain_bit : 1'b1;
   end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
   parameter int KEY_W     = 11,
   parameter int MATCH_N   = 32,
   parameter int TIMEOUT_W = 16
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       locked_o,
   input logic                       plain_o,
   input logic                       filling,
   input logic [KEY_W-1:0]           key_q,
   input logic [$clog2(MATCH_N)-1:0] match_q,
   input logic [TIMEOUT_W-1:0]       timer_q
);
   localparam int MCW = $clog2(MATCH_N);
   localparam logic [MCW-1:0]   MATCH_LAST = MCW'(MATCH_N - 1);
   localparam logic [KEY_W-1:0] KEY_ESCAPE = KEY_W'(1);

   assert_plain_idle_when_unlocked_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(locked_o) |-> plain_o);

   assert_lock_after_full_count_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(locked_o) |-> $past(match_q) == MATCH_LAST);

   assert_key_escape_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (!filling && key_q == '0) |=> key_q == KEY_ESCAPE);

   assert_locked_key_live_R6: assert property (@(posedge clk) disable iff (rst)
      locked_o |-> key_q != '0);

   assert_drop_only_on_expiry_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(locked_o) |-> $past(timer_q) == '1);
endmodule

bind idle_lock_descrambler dsc_checker #(
   .KEY_W(KEY_W), .MATCH_N(MATCH_N), .TIMEOUT_W(TIMEOUT_W)
) i_dsc_checker (
   .clk(clk), .rst(rst), .locked_o(locked_o), .plain_o(plain_o),
   .filling(filling), .key_q(key_q), .match_q(match_q), .timer_q(timer_q)
);

// File: tb/test_idle_lock_descrambler.sv
module test_idle_lock_descrambler;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cipher_in = 1'b1;
   logic plain_o, locked_o;

   int total = 0;
   int fails = 0;
   logic [10:0] txk;   // transmitter key register, free running

   always #2 clk = ~clk;   // 250 MHz

   idle_lock_descrambler i_idle_lock_descrambler (
      .clk(clk), .rst(rst), .cipher_in(cipher_in),
      .plain_o(plain_o), .locked_o(locked_o)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // one line bit; plaintext expectation uses the lock flag seen before the edge
   task automatic drive(input logic c, input logic exp_p, input string req);
      logic lk;
      @(negedge clk);
      rst = 1'b0;
      cipher_in = c;
      lk = locked_o;
      @(posedge clk);
      #1;
      chk(plain_o, lk ? exp_p : 1'b1, req, "plain_o");
   endtask

   task automatic send(input logic p, input string req);
      logic kb;
      kb  = txk[10] ^ txk[8];
      txk = {txk[9:0], kb};
      drive(p ^ kb, p, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic seen;
      void'($urandom(32'd7321));
      txk = 11'($urandom);
      if (txk == '0) txk = 11'h001;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(locked_o, 1'b0, "R1", "locked_o in reset");
      chk(plain_o, 1'b1, "R1", "plain_o in reset");

      // R3: lock latency on idle, R2 ones while unlocked
      for (int i = 0; i < 42; i++) send(1'b1, "R2");
      chk(locked_o, 1'b0, "R3", "locked_o after 42 idle bits");
      send(1'b1, "R2");
      chk(locked_o, 1'b1, "R3", "locked_o after 43 idle bits");

      // R4: random frames separated by idle, key keeps stepping
      for (int i = 0; i < 100; i++)  send(1'b1, "R4");
      for (int i = 0; i < 500; i++)  send(1'($urandom), "R4");
      for (int i = 0; i < 200; i++)  send(1'b1, "R4");
      for (int i = 0; i < 1500; i++) send(1'($urandom), "R4");
      for (int i = 0; i < 100; i++)  send(1'b1, "R4");
      chk(locked_o, 1'b1, "R4", "lock held across frames");

      // R5: corrupted idle bit during acquisition restarts matching
      do_reset();
      for (int i = 0; i < 20; i++) send(1'b1, "R5");
      send(1'b0, "R5");
      for (int i = 0; i < 22; i++) send(1'b1, "R5");
      chk(locked_o, 1'b0, "R5", "no lock by bit 43 after corruption");
      seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         send(1'b1, "R5");
         if (locked_o) seen = 1'b1;
      end
      chk(seen, 1'b1, "R5", "lock reached after restart");
      for (int i = 0; i < 300; i++) send(1'($urandom), "R5");

      // R6: constant ones on the line (zero guess) never locks
      do_reset();
      seen = 1'b0;
      for (int i = 0; i < 300; i++) begin
         drive(1'b1, 1'b1, "R6");
         if (locked_o) seen = 1'b1;
      end
      chk(seen, 1'b0, "R6", "lock on all-ones line");

      // R7: idle timeout drops lock on the 65536th non-idle bit
      do_reset();
      for (int i = 0; i < 43; i++) send(1'b1, "R7");
      chk(locked_o, 1'b1, "R7", "lock before timeout run");
      for (int i = 0; i < 65535; i++) send(1'(i & 1), "R7");
      chk(locked_o, 1'b1, "R7", "lock one bit before expiry");
      send(1'b1, "R7");   // 65536th alternating bit (index 65535 is odd)
      chk(locked_o, 1'b0, "R7", "lock after expiry");

      // R8: reacquire after drop
      for (int i = 0; i < 42; i++) send(1'b1, "R8");
      chk(locked_o, 1'b0, "R8", "relock after 42 bits");
      send(1'b1, "R8");
      chk(locked_o, 1'b1, "R8", "relock after 43 bits");
      for (int i = 0; i < 300; i++) send(1'($urandom), "R8");
      for (int i = 0; i < 50; i++)  send(1'b1, "R8");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule